// File: doc/BRIEF.md
# Banked Multi-Lane Row Store

This block holds one hash word per row and lets a client fetch a whole aligned group of consecutive rows in a single request. The rows are spread over `LANES` independent banks. Consecutive rows fall into different banks, so every row of an aligned group sits in its own bank and all of them can be read in the same clock.

Writes arrive one row per clock as a strobe, a row index and a hash word. A read request carries a base row and a one-cycle valid pulse. One clock later the block returns, for every lane, the row index and its stored hash, together with a per-lane valid mask and an overall valid flag. A base row that does not start an aligned group yields no result. A lane whose row lies past the configured row count is flagged invalid.

Top module: `banked_row_store`

## Requirements
- R1: While `wr_en_i` is high and `wr_idx_i` < ROWS, `wr_data_i` is stored for row `wr_idx_i` at that clock edge. A write with `wr_idx_i` >= ROWS changes no stored row.
- R2: `rs_valid_o` is high in the cycle after an accepted request (`rq_valid_i` high with `rq_base_i` a multiple of LANES). It is low in every other cycle after reset.
- R3: On a valid result, lane i of `rs_idx_o`, in bits [i*ROW_W +: ROW_W], carries `rq_base_i` + i.
- R4: On a valid result, lane i of `rs_data_o`, in bits [i*HASH_W +: HASH_W], carries the hash last written to row base + i.
- R5: A row's bank is its low log2(LANES) index bits and its in-bank address is the remaining upper bits. Rows of different aligned groups never alias, so the group at base k*LANES returns exactly the hashes written to those rows.
- R6: An accepted request whose whole group lies below ROWS gives an all-ones `rs_lane_mask_o`.
- R7: A request whose base has any of its low log2(LANES) bits set gives `rs_valid_o` = 0 and `rs_lane_mask_o` = 0 in the next cycle.
- R8: For an accepted request, mask bit i is 0 when base + i >= ROWS, and `rs_valid_o` is still 1.
- R9: When a write and an accepted read touch the same row in one clock, the read returns the value held before that write.
- R10: Synchronous reset clears `rs_valid_o` and `rs_lane_mask_o` and takes priority over a request in the same cycle. Stored rows keep their contents across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | ROW_W | Row written |
| wr_data_i | input | HASH_W | Hash word written |
| rq_valid_i | input | 1 | Read request pulse |
| rq_base_i | input | ROW_W | First row of the requested group |
| rs_valid_o | output | 1 | Result valid, one cycle after request |
| rs_lane_mask_o | output | LANES | Per-lane valid bits |
| rs_idx_o | output | LANES*ROW_W | Packed row indices, lane i at [i*ROW_W +: ROW_W] |
| rs_data_o | output | LANES*HASH_W | Packed hashes, lane i at [i*HASH_W +: HASH_W] |

## Verification
The bench builds the block with LANES=4, ROWS=22 and HASH_W=12, so ROW_W is 5 and every one of the 32 possible base values can be swept, both aligned and misaligned. Because ROWS is not a multiple of LANES, the group at base 20 is only half populated and the groups at 24 and 28 lie entirely out of range, which exercises the lane-mask clipping. The bank depth of 6 is not a power of two, so in-bank addresses that fall past the end are also reached. Writes of two distinct patterns over every row expose any aliasing between bank addresses. Same-cycle write and read collisions and a reset that arrives together with a request are exercised as well.

// File: rtl/rowstore_pkg.sv
package rowstore_pkg;

   // Width helper: a zero-width field still needs one physical bit.
   function automatic int at_least_one(input int v);
      return (v < 1) ? 1 : v;
   endfunction

   // Number of bank entries needed to hold ROWS rows over LANES banks.
   function automatic int bank_depth(input int rows, input int lanes);
      return (rows + lanes - 1) / lanes;
   endfunction

endpackage

// File: rtl/rowstore_addr_split.sv
module rowstore_addr_split #(
   parameter int ROW_W  = 6,
   parameter int LANE_W = 3,
   parameter int BANK_W = 3,
   parameter int ADDR_W = 3
) (
   input  logic [ROW_W-1:0]  row_i,
   output logic [BANK_W-1:0] bank_o,
   output logic [ADDR_W-1:0] addr_o
);

   generate
      if (LANE_W == 0) begin : g_single_bank
         assign bank_o = '0;
         assign addr_o = row_i;
      end else begin : g_sliced
         assign bank_o = row_i[LANE_W-1:0];
         assign addr_o = row_i[ROW_W-1:LANE_W];
      end
   endgenerate

endmodule

// File: rtl/rowstore_bank.sv
module rowstore_bank #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 3,
   parameter int HASH_W = 32
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [HASH_W-1:0] wdata_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [HASH_W-1:0] rdata_o
);

   logic [HASH_W-1:0] mem [DEPTH];
   logic              raddr_ok;

   assign raddr_ok = ({1'b0, raddr_i} < (ADDR_W+1)'(DEPTH));

   // Read samples the array before this edge's write lands (old value).
   always_ff @(posedge clk) begin
      if (we_i) begin
         mem[waddr_i] <= wdata_i;
      end
      if (re_i && raddr_ok) begin
         rdata_o <= mem[raddr_i];
      end
   end

endmodule

// File: rtl/rowstore_lane_ctrl.sv
module rowstore_lane_ctrl #(
   parameter int ROWS  = 64,
   parameter int LANES = 8,
   parameter int ROW_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rq_valid_i,
   input  logic [ROW_W-1:0] rq_base_i,
   input  logic             aligned_i,
   output logic             rd_en_o,
   output logic             rs_valid_o,
   output logic [LANES-1:0] rs_mask_o,
   output logic [ROW_W-1:0] base_q_o
);

   localparam int CMP_W = ROW_W + 1;

   logic [LANES-1:0] lane_ok;

   assign rd_en_o = rq_valid_i && aligned_i;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane_ok
         assign lane_ok[i] = (({1'b0, rq_base_i} + CMP_W'(i)) < CMP_W'(ROWS));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         rs_valid_o <= 1'b0;
         rs_mask_o  <= '0;
      end else begin
         rs_valid_o <= rd_en_o;
         rs_mask_o  <= rd_en_o ? lane_ok : '0;
      end
      if (rd_en_o) begin
         base_q_o <= rq_base_i;
      end
   end

   // R2: an accepted request yields a result next cycle
   a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
      (rq_valid_i && aligned_i) |=> rs_valid_o);

   // R2: no result without a request in the previous cycle
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
      rs_valid_o |-> $past(rq_valid_i));

   // R6: group fully inside the row range gives a full mask
   a_r6_full_mask: assert property (@(posedge clk) disable iff (rst)
      (rq_valid_i && aligned_i &&
       (({1'b0, rq_base_i} + CMP_W'(LANES)) <= CMP_W'(ROWS)))
      |=> (&rs_mask_o));

   // R7: misaligned request produces nothing
   a_r7_misaligned_silent: assert property (@(posedge clk) disable iff (rst)
      (rq_valid_i && !aligned_i) |=> (!rs_valid_o && rs_mask_o == '0));

   // R10: reset clears flags, even when a request arrives with it
   a_r10_reset_clears: assert property (@(posedge clk)
      rst |=> (!rs_valid_o && rs_mask_o == '0));

endmodule

// File: rtl/banked_row_store.sv
module banked_row_store #(
   parameter int ROWS   = 64,
   parameter int LANES  = 8,
   parameter int HASH_W = 32,
   localparam int ROW_W = $clog2(ROWS)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    wr_en_i,
   input  logic [ROW_W-1:0]        wr_idx_i,
   input  logic [HASH_W-1:0]       wr_data_i,
   input  logic                    rq_valid_i,
   input  logic [ROW_W-1:0]        rq_base_i,
   output logic                    rs_valid_o,
   output logic [LANES-1:0]        rs_lane_mask_o,
   output logic [LANES*ROW_W-1:0]  rs_idx_o,
   output logic [LANES*HASH_W-1:0] rs_data_o
);

   localparam int LANE_W = $clog2(LANES);
   localparam int BANK_W = rowstore_pkg::at_least_one(LANE_W);
   localparam int ADDR_W = ROW_W - LANE_W;
   localparam int DEPTH  = rowstore_pkg::bank_depth(ROWS, LANES);
   localparam int CMP_W  = ROW_W + 1;

   // Elaboration-time parameter checks
   generate
      if (LANES < 1 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("LANES must be a power of two");
      end
      if (ROWS < 2 * LANES) begin : g_bad_rows
         $error("ROWS must be at least twice LANES");
      end
      if (HASH_W < 1) begin : g_bad_hash
         $error("HASH_W must be positive");
      end
   endgenerate

   logic [BANK_W-1:0] wr_bank;
   logic [ADDR_W-1:0] wr_addr;
   logic [BANK_W-1:0] rq_bank;
   logic [ADDR_W-1:0] rq_addr;
   logic              wr_in_range;
   logic              aligned;
   logic              rd_en;
   logic [ROW_W-1:0]  base_q;

   rowstore_addr_split #(
      .ROW_W (ROW_W),
      .LANE_W(LANE_W),
      .BANK_W(BANK_W),
      .ADDR_W(ADDR_W)
   ) wr_split_i (
      .row_i (wr_idx_i),
      .bank_o(wr_bank),
      .addr_o(wr_addr)
   );

   rowstore_addr_split #(
      .ROW_W (ROW_W),
      .LANE_W(LANE_W),
      .BANK_W(BANK_W),
      .ADDR_W(ADDR_W)
   ) rq_split_i (
      .row_i (rq_base_i),
      .bank_o(rq_bank),
      .addr_o(rq_addr)
   );

   assign wr_in_range = ({1'b0, wr_idx_i} < CMP_W'(ROWS));
   assign aligned     = (rq_bank == '0);

   rowstore_lane_ctrl #(
      .ROWS (ROWS),
      .LANES(LANES),
      .ROW_W(ROW_W)
   ) ctrl_i (
      .clk       (clk),
      .rst       (rst),
      .rq_valid_i(rq_valid_i),
      .rq_base_i (rq_base_i),
      .aligned_i (aligned),
      .rd_en_o   (rd_en),
      .rs_valid_o(rs_valid_o),
      .rs_mask_o (rs_lane_mask_o),
      .base_q_o  (base_q)
   );

   generate
      for (genvar b = 0; b < LANES; b++) begin : g_bank
         logic bank_we;

         assign bank_we = wr_en_i && wr_in_range && (wr_bank == BANK_W'(b));

         rowstore_bank #(
            .DEPTH (DEPTH),
            .ADDR_W(ADDR_W),
            .HASH_W(HASH_W)
         ) bank_i (
            .clk    (clk),
            .we_i   (bank_we),
            .waddr_i(wr_addr),
            .wdata_i(wr_data_i),
            .re_i   (rd_en),
            .raddr_i(rq_addr),
            .rdata_o(rs_data_o[b*HASH_W +: HASH_W])
         );

         // Aligned groups put lane b in bank b; row index is the held base plus b.
         assign rs_idx_o[b*ROW_W +: ROW_W] = base_q + ROW_W'(b);

         // R3: lane index matches the request's base plus lane number
         a_r3_lane_index: assert property (@(posedge clk) disable iff (rst)
            rs_valid_o |-> (rs_idx_o[b*ROW_W +: ROW_W] == $past(rq_base_i) + ROW_W'(b)));

         // R8: a set mask bit always names a row inside the configured range
         a_r8_mask_in_range: assert property (@(posedge clk) disable iff (rst)
            rs_lane_mask_o[b] |-> ({1'b0, rs_idx_o[b*ROW_W +: ROW_W]} < CMP_W'(ROWS)));
      end
   endgenerate

   // R8: mask bits only accompany a valid result
   a_r8_mask_needs_valid: assert property (@(posedge clk) disable iff (rst)
      (rs_lane_mask_o != '0) |-> rs_valid_o);

endmodule

// File: tb/banked_row_store_tb_top.sv
module banked_row_store_tb_top;

   localparam int LANES  = 4;
   localparam int ROWS   = 22;
   localparam int HASH_W = 12;
   localparam int ROW_W  = $clog2(ROWS);
   localparam int NBASE  = 1 << ROW_W;

   logic                    clk = 1'b0;
   logic                    rst = 1'b1;
   logic                    wr_en_i = 1'b0;
   logic [ROW_W-1:0]        wr_idx_i = '0;
   logic [HASH_W-1:0]       wr_data_i = '0;
   logic                    rq_valid_i = 1'b0;
   logic [ROW_W-1:0]        rq_base_i = '0;
   logic                    rs_valid_o;
   logic [LANES-1:0]        rs_lane_mask_o;
   logic [LANES*ROW_W-1:0]  rs_idx_o;
   logic [LANES*HASH_W-1:0] rs_data_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [HASH_W-1:0] model [ROWS];

   always #5 clk = ~clk;

   banked_row_store #(
      .ROWS  (ROWS),
      .LANES (LANES),
      .HASH_W(HASH_W)
   ) dut_i (
      .clk           (clk),
      .rst           (rst),
      .wr_en_i       (wr_en_i),
      .wr_idx_i      (wr_idx_i),
      .wr_data_i     (wr_data_i),
      .rq_valid_i    (rq_valid_i),
      .rq_base_i     (rq_base_i),
      .rs_valid_o    (rs_valid_o),
      .rs_lane_mask_o(rs_lane_mask_o),
      .rs_idx_o      (rs_idx_o),
      .rs_data_o     (rs_data_o)
   );

   function automatic logic [HASH_W-1:0] pattern(input int row, input int pass);
      return HASH_W'(row * 151 + pass * 977 + 29);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Called at a falling edge; leaves at the next falling edge.
   task automatic write_row(input int row, input logic [HASH_W-1:0] val);
      wr_en_i   = 1'b1;
      wr_idx_i  = ROW_W'(row);
      wr_data_i = val;
      @(negedge clk);
      wr_en_i = 1'b0;
      if (row < ROWS) model[row] = val;
   endtask

   // Request, then check the registered result one clock later.
   task automatic read_check(input int base, input string tag);
      bit aligned;
      logic [LANES-1:0] exp_mask;
      aligned = (base % LANES) == 0;
      rq_valid_i = 1'b1;
      rq_base_i  = ROW_W'(base);
      @(negedge clk);
      rq_valid_i = 1'b0;
      for (int i = 0; i < LANES; i++) exp_mask[i] = aligned && (base + i < ROWS);
      check(rs_valid_o == aligned, aligned ? {tag, " R2 valid"} : {tag, " R7 valid"},
            rs_valid_o, aligned);
      check(rs_lane_mask_o == exp_mask,
            aligned ? {tag, " R6/R8 mask"} : {tag, " R7 mask"}, rs_lane_mask_o, exp_mask);
      if (aligned) begin
         for (int i = 0; i < LANES; i++) begin
            check(rs_idx_o[i*ROW_W +: ROW_W] == ROW_W'(base + i), {tag, " R3 lane index"},
                  rs_idx_o[i*ROW_W +: ROW_W], base + i);
            if (base + i < ROWS)
               check(rs_data_o[i*HASH_W +: HASH_W] == model[base + i], {tag, " R4/R5 lane hash"},
                     rs_data_o[i*HASH_W +: HASH_W], model[base + i]);
         end
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check(rs_valid_o == 1'b0, "R10 reset valid", rs_valid_o, 0);
      check(rs_lane_mask_o == '0, "R10 reset mask", rs_lane_mask_o, 0);
      rst = 1'b0;
      @(negedge clk);

      // R1/R5: fill every row, then sweep all bases
      for (int r = 0; r < ROWS; r++) write_row(r, pattern(r, 0));
      for (int b = 0; b < NBASE; b++) read_check(b, "pass0");

      // R1: writes past ROWS must not disturb stored rows
      for (int r = ROWS; r < NBASE; r++) write_row(r, pattern(r, 7));

      // R5: second pattern in reverse order to expose aliasing
      for (int r = ROWS - 1; r >= 0; r--) write_row(r, pattern(r, 1));
      for (int b = 0; b < NBASE; b += LANES) read_check(b, "pass1 R1");

      // R9: write and read the same row in one clock
      for (int k = 0; k < ROWS; k += 3) begin
         int base;
         logic [HASH_W-1:0] old_v;
         base  = (k / LANES) * LANES;
         old_v = model[k];
         wr_en_i    = 1'b1;
         wr_idx_i   = ROW_W'(k);
         wr_data_i  = pattern(k, 2);
         rq_valid_i = 1'b1;
         rq_base_i  = ROW_W'(base);
         @(negedge clk);
         wr_en_i    = 1'b0;
         rq_valid_i = 1'b0;
         check(rs_data_o[(k - base)*HASH_W +: HASH_W] == old_v, "R9 old value",
               rs_data_o[(k - base)*HASH_W +: HASH_W], old_v);
         model[k] = pattern(k, 2);
         read_check(base, "R9 after");
      end

      // R2: idle cycle after a result drops the flag
      read_check(4, "R2 pre-idle");
      @(negedge clk);
      check(rs_valid_o == 1'b0, "R2 idle", rs_valid_o, 0);

      // R10: reset wins over a simultaneous request; contents survive
      rst        = 1'b1;
      rq_valid_i = 1'b1;
      rq_base_i  = '0;
      @(negedge clk);
      rq_valid_i = 1'b0;
      check(rs_valid_o == 1'b0, "R10 reset beats request valid", rs_valid_o, 0);
      check(rs_lane_mask_o == '0, "R10 reset beats request mask", rs_lane_mask_o, 0);
      rst = 1'b0;
      @(negedge clk);
      for (int b = 0; b < ROWS; b += LANES) read_check(b, "R10 contents kept");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule